// File: doc/BRIEF.md
# Vector Prefix Detect and Element Step Sequencer

This block sits on the fetch side of a core that runs a 32-bit instruction stream extended with an optional 32-bit vector prefix. Every cycle it looks at the word fetched at the current program counter and decides whether that word is a vector prefix. When it is, the block pulls the 24-bit remap field out of the prefix, splits it into its named fields, and selects the following word (fetched from PC+4) as the instruction to execute. When it is not, the fetched word passes through unchanged and the remap outputs read zero.

The block also owns the 32-bit vector state register and walks its source element step. Each time a prefixed instruction issues one element, the step moves forward and the program counter stays put. When the last element issues, the step returns to zero and the program counter jumps over both words. A plain instruction moves the program counter by one word and leaves the step alone. Software state loads come in through a single write port that replaces the whole state register.

All bit positions below use MSB-first numbering: bit 0 of an N-bit word is its most significant bit, so MSB-first bit k is LSB-first bit N-1-k.

Top module: `vpfx_step_seq`

## Requirements
- R1: A fetched word is a prefix exactly when its bits 0 to 5 equal 0b000001 and both bit 7 and bit 9 are 1; `is_pfx_o` reports this combinationally.
- R2: For a prefix, `remap_o` bit 0 is fetched-word bit 6, `remap_o` bit 1 is fetched-word bit 8, and `remap_o` bits 2 to 23 are fetched-word bits 10 to 31 in the same order.
- R3: The remap field outputs decode `remap_o` as: bit 0 mask mode, bits 1-3 mask, bits 4-5 element width, bits 6-7 source element width, bits 8-9 sub-vector length, bits 10-18 extra, bits 19-23 mode.
- R4: For a word that is not a prefix, `remap_o` and every remap field output are zero, `insn_o` equals the fetched word, and an issue leaves the source step unchanged.
- R5: `state_o` holds the vector state register, decoded as: bits 0-6 maximum length, bits 7-13 vector length, bits 14-20 source step, bits 21-27 destination step, bits 28-29 sub-vector length, bits 30-31 outer step; a write with `st_wr_i` loads the whole register on the next clock edge.
- R6: An issued prefix whose source step is not the last one increments the source step by one and holds the program counter.
- R7: An issued prefix on its last element clears the source step to zero and advances the program counter by 8.
- R8: An issued plain instruction advances the program counter by 4.
- R9: With no issue and no state write, program counter and state register keep their values.
- R10: An element is the last one when the vector length is zero (single pass) or when the unsigned source step is at or above vector length minus one; `elem_last_o` is 1 for any plain instruction and for a prefix on its last element.
- R11: Reset sets the program counter to the `RESET_PC` parameter and the state register to zero.
- R12: `sfx_addr_o` is always the program counter plus 4, and for a prefix `insn_o` equals `next_word_i`.
- R13: When a state write and an issue fall in the same cycle, the state register takes the written value while the program counter still moves by the rule for the issue, judged on the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word_i | input | 32 | Word fetched at the current program counter |
| next_word_i | input | 32 | Word fetched at the program counter plus 4 |
| issue_i | input | 1 | One element (or one plain instruction) issues this cycle |
| st_wr_i | input | 1 | Load the vector state register |
| st_wdata_i | input | 32 | Value to load into the vector state register |
| pc_o | output | PC_W | Current program counter |
| sfx_addr_o | output | PC_W | Fetch address of the suffix word |
| is_pfx_o | output | 1 | Fetched word is a vector prefix |
| insn_o | output | 32 | Instruction selected for execution |
| remap_o | output | 24 | Gathered remap field, zero for plain words |
| rm_msk_mode_o | output | 1 | Remap mask mode |
| rm_mask_o | output | 3 | Remap mask selector |
| rm_elw_o | output | 2 | Remap element width |
| rm_src_elw_o | output | 2 | Remap source element width |
| rm_subvl_o | output | 2 | Remap sub-vector length |
| rm_extra_o | output | 9 | Remap extra field |
| rm_mode_o | output | 5 | Remap mode |
| state_o | output | 32 | Vector state register |
| maxvl_o | output | 7 | Maximum vector length field |
| vl_o | output | 7 | Vector length field |
| srcstep_o | output | 7 | Source element step field |
| elem_last_o | output | 1 | The current issue ends the instruction and moves the program counter |

## Verification
A wrong step count shows at the ports within one clock: `srcstep_o` takes the wrong value, and the cycle on which `pc_o` leaves its held value moves early or late, so a step that fails to wrap leaves the program counter frozen for good. A wrong last-element rule shows up as `elem_last_o` disagreeing with the loop length before the edge, then as a wrong increment of 0, 4 or 8 right after it. Decode errors in the prefix test or the remap gather are combinational and show in the same cycle on `is_pfx_o`, `insn_o` and the remap field outputs. Vector lengths of zero and source steps loaded beyond the length are driven on purpose, because a wrong compare there hangs the loop.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;

   localparam int WORD_W = 32;
   localparam int RM_W   = 24;
   localparam int ST_W   = 32;
   localparam int STEP_W = 7;
   localparam int MAJ_W  = 6;

   localparam logic [MAJ_W-1:0] PFX_MAJOR = 6'b000001;

   // MSB-first bit positions of the identity bits inside a prefix word
   localparam int PFX_ID_A = 7;
   localparam int PFX_ID_B = 9;

   // Remap layout, most significant member first (MSB-first bit 0 on top)
   typedef struct packed {
      logic       msk_mode;
      logic [2:0] mask;
      logic [1:0] elw;
      logic [1:0] src_elw;
      logic [1:0] subvl;
      logic [8:0] extra;
      logic [4:0] mode;
   } remap_t;

   // Vector state layout, most significant member first
   typedef struct packed {
      logic [STEP_W-1:0] maxvl;
      logic [STEP_W-1:0] vl;
      logic [STEP_W-1:0] srcstep;
      logic [STEP_W-1:0] dststep;
      logic [1:0]        subvl;
      logic [1:0]        svstep;
   } vstate_t;

   // LSB-first index of MSB-first bit k in a word of width w
   function automatic int lsb_idx(input int k, input int w);
      return w - 1 - k;
   endfunction

   // MSB-first source bit in the fetched word for remap bit g
   function automatic int remap_src(input int g);
      if (g == 0) return 6;
      if (g == 1) return 8;
      return g + 8;
   endfunction

endpackage

// File: rtl/vpfx_detect.sv
module vpfx_detect
   import vpfx_pkg::*;
#(
   parameter int W_WORD = WORD_W,
   parameter int W_RM   = RM_W
) (
   input  logic [W_WORD-1:0] word_i,
   output logic              is_pfx_o,
   output logic [W_RM-1:0]   remap_o
);

   localparam int MAJ_HI = W_WORD - 1;

   if (W_WORD != 32) begin : g_bad_word
      $error("vpfx_detect: word width must be 32");
   end
   if (W_RM != 24) begin : g_bad_rm
      $error("vpfx_detect: remap width must be 24");
   end

   logic [MAJ_W-1:0] major;
   logic             id_a;
   logic             id_b;
   logic [W_RM-1:0]  gathered;

   assign major = word_i[MAJ_HI -: MAJ_W];
   assign id_a  = word_i[lsb_idx(PFX_ID_A, W_WORD)];
   assign id_b  = word_i[lsb_idx(PFX_ID_B, W_WORD)];

   for (genvar g = 0; g < W_RM; g++) begin : g_gather
      assign gathered[lsb_idx(g, W_RM)] = word_i[lsb_idx(remap_src(g), W_WORD)];
   end

   always_comb begin
      is_pfx_o = (major == PFX_MAJOR) && id_a && id_b;
      remap_o  = is_pfx_o ? gathered : '0;
   end

endmodule

// File: rtl/vpfx_step.sv
module vpfx_step
   import vpfx_pkg::*;
#(
   parameter int W_ST   = ST_W,
   parameter int W_STEP = STEP_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_wr_i,
   input  logic [W_ST-1:0] st_wdata_i,
   input  logic            adv_i,
   output vstate_t         state_o,
   output logic            last_o
);

   if (W_ST != $bits(vstate_t)) begin : g_bad_st
      $error("vpfx_step: state width mismatch");
   end
   if (W_STEP != STEP_W) begin : g_bad_step
      $error("vpfx_step: step width mismatch");
   end

   localparam logic [W_STEP:0] ONE_X = (W_STEP+1)'(1);

   vstate_t           st_q;
   vstate_t           st_d;
   logic [W_STEP:0]   step_p1;
   logic [W_STEP:0]   vl_x;
   logic              vl_zero;

   always_comb begin
      step_p1 = {1'b0, st_q.srcstep} + ONE_X;
      vl_x    = {1'b0, st_q.vl};
      vl_zero = (st_q.vl == '0);
      last_o  = vl_zero || (step_p1 >= vl_x);
   end

   always_comb begin
      st_d = st_q;
      if (st_wr_i) begin
         st_d = vstate_t'(st_wdata_i);
      end else if (adv_i) begin
         st_d.srcstep = last_o ? '0 : step_p1[W_STEP-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/vpfx_pc.sv
module vpfx_pc #(
   parameter int              W_PC     = 32,
   parameter logic [W_PC-1:0] PC_RESET = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_i,
   input  logic            pfx_i,
   input  logic            last_i,
   output logic [W_PC-1:0] pc_o,
   output logic [W_PC-1:0] sfx_addr_o
);

   if (W_PC < 4) begin : g_bad_pc
      $error("vpfx_pc: program counter too narrow");
   end

   localparam logic [W_PC-1:0] STEP_ONE = W_PC'(4);
   localparam logic [W_PC-1:0] STEP_TWO = W_PC'(8);

   logic [W_PC-1:0] pc_q;
   logic [W_PC-1:0] pc_inc;

   always_comb begin
      pc_inc = '0;
      if (issue_i) begin
         if (!pfx_i)      pc_inc = STEP_ONE;
         else if (last_i) pc_inc = STEP_TWO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_RESET;
      else        pc_q <= pc_q + pc_inc;
   end

   assign pc_o       = pc_q;
   assign sfx_addr_o = pc_q + STEP_ONE;

endmodule

// File: rtl/vpfx_step_seq.sv
module vpfx_step_seq
   import vpfx_pkg::*;
#(
   parameter int              PC_W     = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      fetch_word_i,
   input  logic [31:0]      next_word_i,
   input  logic             issue_i,
   input  logic             st_wr_i,
   input  logic [31:0]      st_wdata_i,
   output logic [PC_W-1:0]  pc_o,
   output logic [PC_W-1:0]  sfx_addr_o,
   output logic             is_pfx_o,
   output logic [31:0]      insn_o,
   output logic [23:0]      remap_o,
   output logic             rm_msk_mode_o,
   output logic [2:0]       rm_mask_o,
   output logic [1:0]       rm_elw_o,
   output logic [1:0]       rm_src_elw_o,
   output logic [1:0]       rm_subvl_o,
   output logic [8:0]       rm_extra_o,
   output logic [4:0]       rm_mode_o,
   output logic [31:0]      state_o,
   output logic [6:0]       maxvl_o,
   output logic [6:0]       vl_o,
   output logic [6:0]       srcstep_o,
   output logic             elem_last_o
);

   if ($bits(remap_t) != RM_W) begin : g_bad_remap
      $error("vpfx_step_seq: remap layout width mismatch");
   end

   logic    pfx;
   logic    loop_last;
   remap_t  rm;
   vstate_t st;

   vpfx_detect #(
      .W_WORD (WORD_W),
      .W_RM   (RM_W)
   ) u_detect (
      .word_i   (fetch_word_i),
      .is_pfx_o (pfx),
      .remap_o  (rm)
   );

   vpfx_step #(
      .W_ST   (ST_W),
      .W_STEP (STEP_W)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_wr_i    (st_wr_i),
      .st_wdata_i (st_wdata_i),
      .adv_i      (issue_i && pfx),
      .state_o    (st),
      .last_o     (loop_last)
   );

   vpfx_pc #(
      .W_PC     (PC_W),
      .PC_RESET (RESET_PC)
   ) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_i    (issue_i),
      .pfx_i      (pfx),
      .last_i     (loop_last),
      .pc_o       (pc_o),
      .sfx_addr_o (sfx_addr_o)
   );

   always_comb begin
      is_pfx_o      = pfx;
      insn_o        = pfx ? next_word_i : fetch_word_i;
      remap_o       = rm;
      rm_msk_mode_o = rm.msk_mode;
      rm_mask_o     = rm.mask;
      rm_elw_o      = rm.elw;
      rm_src_elw_o  = rm.src_elw;
      rm_subvl_o    = rm.subvl;
      rm_extra_o    = rm.extra;
      rm_mode_o     = rm.mode;
      state_o       = st;
      maxvl_o       = st.maxvl;
      vl_o          = st.vl;
      srcstep_o     = st.srcstep;
      elem_last_o   = !pfx || loop_last;
   end

endmodule

// File: rtl/vpfx_step_seq_chk.sv
module vpfx_step_seq_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [31:0]     fetch_word_i,
   input logic [31:0]     next_word_i,
   input logic            issue_i,
   input logic            st_wr_i,
   input logic [31:0]     st_wdata_i,
   input logic [PC_W-1:0] pc_o,
   input logic [PC_W-1:0] sfx_addr_o,
   input logic            is_pfx_o,
   input logic [31:0]     insn_o,
   input logic [23:0]     remap_o,
   input logic            rm_msk_mode_o,
   input logic [2:0]      rm_mask_o,
   input logic [1:0]      rm_elw_o,
   input logic [1:0]      rm_src_elw_o,
   input logic [1:0]      rm_subvl_o,
   input logic [8:0]      rm_extra_o,
   input logic [4:0]      rm_mode_o,
   input logic [31:0]     state_o,
   input logic [6:0]      maxvl_o,
   input logic [6:0]      vl_o,
   input logic [6:0]      srcstep_o,
   input logic            elem_last_o
);

   localparam logic [PC_W-1:0] FOUR  = PC_W'(4);
   localparam logic [PC_W-1:0] EIGHT = PC_W'(8);

   AST_PLAIN_NO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
      !is_pfx_o |-> (remap_o == '0 && insn_o == fetch_word_i)); // R4

   AST_PFX_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && is_pfx_o && !elem_last_o && !st_wr_i)
      |=> ($stable(pc_o) && srcstep_o == $past(srcstep_o) + 7'd1)); // R6

   AST_PFX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && is_pfx_o && elem_last_o && !st_wr_i)
      |=> (pc_o == $past(pc_o) + EIGHT && srcstep_o == '0)); // R7

   AST_PLAIN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !is_pfx_o && !st_wr_i)
      |=> (pc_o == $past(pc_o) + FOUR && $stable(state_o))); // R8

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_i && !st_wr_i) |=> ($stable(pc_o) && $stable(state_o))); // R9

   AST_ZERO_VL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (vl_o == '0) |-> elem_last_o); // R10

   AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_i |=> (state_o == $past(st_wdata_i))); // R5

   AST_SFX_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      sfx_addr_o == pc_o + FOUR); // R12

endmodule

bind vpfx_step_seq vpfx_step_seq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/vpfx_step_seq_tb.sv
module vpfx_step_seq_tb;

   localparam int          PC_W   = 32;
   localparam logic [31:0] RST_PC = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_word_i = '0;
   logic [31:0] next_word_i = '0;
   logic        issue_i = 1'b0;
   logic        st_wr_i = 1'b0;
   logic [31:0] st_wdata_i = '0;
   logic [31:0] pc_o, sfx_addr_o, insn_o, state_o;
   logic        is_pfx_o, rm_msk_mode_o, elem_last_o;
   logic [23:0] remap_o;
   logic [2:0]  rm_mask_o;
   logic [1:0]  rm_elw_o, rm_src_elw_o, rm_subvl_o;
   logic [8:0]  rm_extra_o;
   logic [4:0]  rm_mode_o;
   logic [6:0]  maxvl_o, vl_o, srcstep_o;

   always #5 clk = ~clk;

   vpfx_step_seq #(.PC_W(PC_W), .RESET_PC(RST_PC)) u_dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] ref_pc;
   logic [31:0] ref_st;
   string pc_tag = "R11";

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // MSB-first field of a 32-bit word
   function automatic logic [31:0] wfld(input logic [31:0] w, input int a, input int b);
      logic [31:0] r = '0;
      for (int k = a; k <= b; k++) r = (r << 1) | 32'(w[31-k]);
      return r;
   endfunction

   function automatic logic [31:0] rfld(input logic [23:0] w, input int a, input int b);
      logic [31:0] r = '0;
      for (int k = a; k <= b; k++) r = (r << 1) | 32'(w[23-k]);
      return r;
   endfunction

   function automatic bit m_pfx(input logic [31:0] w);
      return wfld(w, 0, 5) == 32'd1 && w[31-7] && w[31-9];
   endfunction

   function automatic logic [23:0] m_remap(input logic [31:0] w);
      logic [23:0] r = '0;
      int src;
      for (int k = 0; k < 24; k++) begin
         src = (k == 0) ? 6 : (k == 1) ? 8 : k + 8;
         r = {r[22:0], w[31-src]};
      end
      return r;
   endfunction

   function automatic bit m_last(input logic [31:0] st);
      int vl = int'(wfld(st, 7, 13));
      int ss = int'(wfld(st, 14, 20));
      return (vl == 0) || (ss + 1 >= vl);
   endfunction

   function automatic logic [31:0] mkst(input int mx, input int vl, input int ss, input int ds);
      return {mx[6:0], vl[6:0], ss[6:0], ds[6:0], 2'b01, 2'b10};
   endfunction

   function automatic logic [31:0] mkpfx(input logic [23:0] rm);
      return {6'b000001, rm[23], 1'b1, rm[22], 1'b1, rm[21:0]};
   endfunction

   task automatic cyc(input logic [31:0] w0, input logic [31:0] w1, input bit iss,
                      input bit swr, input logic [31:0] sdat);
      bit p, lst;
      logic [23:0] rm;
      int ss;
      fetch_word_i = w0; next_word_i = w1; issue_i = iss; st_wr_i = swr; st_wdata_i = sdat;
      #1;
      p   = m_pfx(w0);
      rm  = p ? m_remap(w0) : 24'd0;
      lst = !p || m_last(ref_st);
      chk("R1 prefix detect", 64'(is_pfx_o), 64'(p));
      chk("R2 remap gather", 64'(remap_o), 64'(rm));
      chk("R3 remap fields", {30'd0, rm_msk_mode_o, rm_mask_o, rm_elw_o, rm_src_elw_o,
                              rm_subvl_o, rm_extra_o, rm_mode_o},
          {30'd0, rfld(rm,0,0)[0], rfld(rm,1,3)[2:0], rfld(rm,4,5)[1:0], rfld(rm,6,7)[1:0],
           rfld(rm,8,9)[1:0], rfld(rm,10,18)[8:0], rfld(rm,19,23)[4:0]});
      chk(p ? "R12 suffix insn" : "R4 plain insn", 64'(insn_o), 64'(p ? w1 : w0));
      chk("R12 suffix addr", 64'(sfx_addr_o), 64'(ref_pc + 32'd4));
      chk(pc_tag, 64'(pc_o), 64'(ref_pc));
      chk("R5 state", 64'(state_o), 64'(ref_st));
      chk("R5 fields", {43'd0, maxvl_o, vl_o, srcstep_o},
          {43'd0, wfld(ref_st,0,6)[6:0], wfld(ref_st,7,13)[6:0], wfld(ref_st,14,20)[6:0]});
      chk("R10 last element", 64'(elem_last_o), 64'(lst));
      @(posedge clk);
      if (!iss)                pc_tag = "R9 idle pc";
      else if (swr)            pc_tag = "R13 write+issue pc";
      else if (!p)             pc_tag = "R8 plain pc";
      else if (lst)            pc_tag = "R7 wrap pc";
      else                     pc_tag = "R6 hold pc";
      if (iss) ref_pc = ref_pc + (!p ? 32'd4 : (lst ? 32'd8 : 32'd0));
      if (swr) ref_st = sdat;
      else if (iss && p) begin
         ss = lst ? 0 : int'(wfld(ref_st, 14, 20)) + 1;
         ref_st[17:11] = ss[6:0];
      end
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] pw, w;
      repeat (3) @(negedge clk);
      chk("R11 reset pc", 64'(pc_o), 64'(RST_PC));
      chk("R11 reset state", 64'(state_o), 64'd0);
      rst_n = 1'b1;
      ref_pc = RST_PC;
      ref_st = '0;
      @(negedge clk);

      pw = mkpfx(24'hA5_C3_96);
      // R5: load vl=3 then R6/R7 loop walk
      cyc(32'h1234_5678, 0, 0, 1, mkst(8, 3, 0, 2));
      cyc(pw, 32'hCAFE_0001, 1, 0, 0);
      cyc(pw, 32'hCAFE_0001, 1, 0, 0);
      cyc(pw, 32'hCAFE_0001, 1, 0, 0);
      cyc(pw, 32'hCAFE_0001, 0, 0, 0);   // R9 idle on prefix
      // R8 plain, R4 step untouched
      cyc(32'h3800_0001, 32'h0, 1, 0, 0);
      cyc(32'h0600_0000, 32'h0, 1, 0, 0); // near prefix: bits 7/9 clear
      cyc(32'h0500_0000, 32'h0, 1, 0, 0); // bit 7 only set
      // R10: vl zero single pass
      cyc(0, 0, 0, 1, mkst(4, 0, 0, 0));
      cyc(mkpfx(24'hFFFFFF), 32'h11, 1, 0, 0);
      // R10: source step beyond length
      cyc(0, 0, 0, 1, mkst(4, 3, 6, 0));
      cyc(mkpfx(24'h000001), 32'h22, 1, 0, 0);
      // R13: write and issue together
      cyc(0, 0, 0, 1, mkst(4, 5, 1, 0));
      cyc(pw, 32'h33, 1, 1, mkst(9, 2, 1, 3));
      cyc(pw, 32'h33, 1, 0, 0);
      cyc(pw, 32'h33, 1, 1, mkst(9, 4, 0, 0));
      cyc(pw, 32'h33, 0, 0, 0);
      // R2/R3 single-bit walks through the remap field
      for (int k = 0; k < 24; k++) cyc(mkpfx(24'h800000 >> k), 32'h44, 0, 0, 0);

      for (int i = 0; i < 600; i++) begin
         w = $urandom;
         if ($urandom % 2 == 0) begin
            w[31:26] = 6'b000001; w[24] = 1'b1; w[22] = 1'b1;
         end
         cyc(w, $urandom, ($urandom % 4) != 0, ($urandom % 9) == 0,
             mkst(int'($urandom % 128), int'($urandom % 6), int'($urandom % 8), 0));
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule